// File: doc/BRIEF.md
# Memory-Mapped Console FIFO Peripheral

This block is a character console that sits on a simple register bus. Software reaches it through two 32-bit words. The data word at offset 0x0 works in two directions. A read takes the oldest received byte out of the receive FIFO and returns it along with a valid flag and the number of bytes still queued. A write places the low byte of the write data into the transmit FIFO. The control word at offset 0x4 holds:
- the two interrupt enables;
- the two pending flags;
- a sticky activity flag that software clears by writing 1 to it;
- the free space left in the transmit FIFO.

The host side uses two plain valid/ready byte streams. One delivers bytes into the receive FIFO. The other takes bytes from the transmit FIFO. A read request on the bus is accepted at a clock edge, and the read word appears on `bus_rdata` after that edge. The word holds its value until the next read. Any other offset reads as zero, and writes to any other offset are ignored.

Top module: `console_fifo_periph`

## Requirements
- R1: After reset both FIFOs are empty, both enables are 0 and the activity flag is 0. With default parameters, a control read returns 0x0040_0200: free space 64, write-pending 1, every other bit 0.
- R2: A data read returns a word with the received byte in bits 7:0, valid = 1 in bit 15, zero in bits 14:8, and in bits 31:16 the count of bytes left after the returned one.
- R3: Each data read removes the returned byte. Successive reads return the bytes in arrival order.
- R4: A data read of an empty receive FIFO returns bit 15 = 0 and bits 31:16 = 0, and changes no state.
- R5: A data write pushes bits 7:0 into the transmit FIFO, and bits 31:8 are ignored. Bytes leave on `tx_data` in write order. `tx_valid` stays high and `tx_data` stays stable until `tx_ready` accepts the byte.
- R6: A data write while the transmit FIFO holds DEPTH bytes is dropped. The stored bytes are left unchanged.
- R7: `rx_ready` is low while the receive FIFO holds DEPTH bytes, so no further byte is accepted.
- R8: In the control word, bit 0 is the read-interrupt enable and bit 1 is the write-interrupt enable. Both read back as written. Bits 7:2 and 15:11 read as zero. Bits 31:16 give the free space in the transmit FIFO.
- R9: Control bit 8 is 1 while the receive FIFO holds at least RX_THRESH bytes (default 1). Control bit 9 is 1 while the transmit free space is at least TX_THRESH (default DEPTH/2).
- R10: `irq` is high exactly when (bit 8 and bit 0) or (bit 9 and bit 1) holds.
- R11: Control bit 10 becomes 1 after any cycle with a completed host-side transfer, in either direction. Writing 1 to bit 10 clears it. Writing 0 to bit 10 leaves it unchanged.
- R12: A host-side transfer in the same cycle as a write-1 clear leaves the activity flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read word, valid after the accepting edge |
| rx_valid | input | 1 | Host offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive FIFO can accept a byte |
| tx_valid | output | 1 | Transmit FIFO has a byte |
| tx_data | output | 8 | Head of the transmit FIFO |
| tx_ready | input | 1 | Host takes the transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that a bus access lasts a single cycle. They also assume the host keeps `rx_valid` and `tx_ready` as plain level signals, with no dependence on outputs in the same cycle beyond the ready/valid rule. The stimulus tasks drive every input on the falling edge and hold a request for exactly one rising edge. No bus access and host transfer overlap, except in the one test that deliberately lines up a clear of the activity flag with a received byte. Fill tests push each FIFO exactly to DEPTH, and then one past it, to reach the full boundary.

// File: rtl/console_pkg.sv
package console_pkg;

   localparam int unsigned REG_W = 32;

   // word offsets decoded by the bus side
   localparam int unsigned DATA_OFF = 0;
   localparam int unsigned CTRL_OFF = 4;

   // control word bit positions used by write decode
   localparam int unsigned BIT_RD_EN  = 0;
   localparam int unsigned BIT_WR_EN  = 1;
   localparam int unsigned BIT_ACTIVE = 10;

   typedef struct packed {
      logic [15:0] avail;
      logic        valid;
      logic [6:0]  zero;
      logic [7:0]  chr;
   } data_word_t;

   typedef struct packed {
      logic [15:0] tx_free;
      logic [4:0]  zero_hi;
      logic        active;
      logic        wr_pend;
      logic        rd_pend;
      logic [5:0]  zero_lo;
      logic        wr_en;
      logic        rd_en;
   } ctrl_word_t;

endpackage

// File: rtl/cons_fifo.sv
module cons_fifo #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned W     = 8,
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("cons_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wptr, rptr, wnext, rnext;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rptr];

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wnext = wptr + PW'(1);
      assign rnext = rptr + PW'(1);
   end else begin : g_modulo
      assign wnext = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);
      assign rnext = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + PW'(1);
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wnext;
         if (do_pop)  rptr <= rnext;
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/cons_ctrl.sv
module cons_ctrl #(
   parameter int unsigned DEPTH     = 64,
   parameter int unsigned RX_THRESH = 1,
   parameter int unsigned TX_THRESH = DEPTH / 2,
   localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_wr,
   input  logic [31:0]   wdata,
   input  logic [CW-1:0] rx_cnt,
   input  logic [CW-1:0] tx_free,
   input  logic          rx_xfer,
   input  logic          tx_xfer,
   output logic          rd_en,
   output logic          wr_en,
   output logic          rd_pend,
   output logic          wr_pend,
   output logic          active,
   output logic          irq
);
   import console_pkg::*;

   if (RX_THRESH < 1 || RX_THRESH > DEPTH) begin : g_bad_rx
      $error("cons_ctrl: RX_THRESH out of range");
   end
   if (TX_THRESH > DEPTH) begin : g_bad_tx
      $error("cons_ctrl: TX_THRESH out of range");
   end

   assign rd_pend = (rx_cnt >= CW'(RX_THRESH));
   assign wr_pend = (tx_free >= CW'(TX_THRESH));
   assign irq     = (rd_pend && rd_en) || (wr_pend && wr_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_en  <= 1'b0;
         wr_en  <= 1'b0;
         active <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            rd_en <= wdata[BIT_RD_EN];
            wr_en <= wdata[BIT_WR_EN];
         end
         if (rx_xfer || tx_xfer)
            active <= 1'b1;
         else if (ctrl_wr && wdata[BIT_ACTIVE])
            active <= 1'b0;
      end
   end

endmodule

// File: rtl/console_fifo_periph.sv
module console_fifo_periph #(
   parameter int unsigned DEPTH     = 64,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned RX_THRESH = 1,
   parameter int unsigned TX_THRESH = DEPTH / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   input  logic              tx_ready,
   output logic              irq
);
   import console_pkg::*;

   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH > 65535) begin : g_bad_depth
      $error("console_fifo_periph: DEPTH must fit the 16-bit count fields");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("console_fifo_periph: ADDR_W must reach offset 4");
   end

   logic          hit_data, hit_ctrl, rd_acc, wr_acc;
   logic          rx_full, rx_empty, tx_full, tx_empty;
   logic [7:0]    rx_head;
   logic [CW-1:0] rx_cnt, tx_cnt, tx_free;
   logic          rx_xfer, tx_xfer;
   logic          rd_en, wr_en, rd_pend, wr_pend, act_flag;
   data_word_t    dword;
   ctrl_word_t    cword;

   assign hit_data = (bus_addr == ADDR_W'(DATA_OFF));
   assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_OFF));
   assign rd_acc   = bus_sel && !bus_wr;
   assign wr_acc   = bus_sel && bus_wr;

   assign rx_ready = !rx_full;
   assign rx_xfer  = rx_valid && rx_ready;
   assign tx_valid = !tx_empty;
   assign tx_xfer  = tx_valid && tx_ready;
   assign tx_free  = CW'(DEPTH) - tx_cnt;

   cons_fifo #(.DEPTH(DEPTH), .W(8)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_valid),
      .din   (rx_data),
      .pop   (rd_acc && hit_data),
      .dout  (rx_head),
      .count (rx_cnt),
      .full  (rx_full),
      .empty (rx_empty)
   );

   cons_fifo #(.DEPTH(DEPTH), .W(8)) u_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_acc && hit_data),
      .din   (bus_wdata[7:0]),
      .pop   (tx_ready),
      .dout  (tx_data),
      .count (tx_cnt),
      .full  (tx_full),
      .empty (tx_empty)
   );

   cons_ctrl #(
      .DEPTH     (DEPTH),
      .RX_THRESH (RX_THRESH),
      .TX_THRESH (TX_THRESH)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_wr (wr_acc && hit_ctrl),
      .wdata   (bus_wdata),
      .rx_cnt  (rx_cnt),
      .tx_free (tx_free),
      .rx_xfer (rx_xfer),
      .tx_xfer (tx_xfer),
      .rd_en   (rd_en),
      .wr_en   (wr_en),
      .rd_pend (rd_pend),
      .wr_pend (wr_pend),
      .active  (act_flag),
      .irq     (irq)
   );

   always_comb begin
      dword       = '0;
      dword.valid = !rx_empty;
      dword.chr   = rx_empty ? 8'h00 : rx_head;
      dword.avail = rx_empty ? 16'd0 : 16'(rx_cnt - CW'(1));
   end

   always_comb begin
      cword         = '0;
      cword.tx_free = 16'(tx_free);
      cword.active  = act_flag;
      cword.wr_pend = wr_pend;
      cword.rd_pend = rd_pend;
      cword.wr_en   = wr_en;
      cword.rd_en   = rd_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_acc) begin
         if (hit_data)      bus_rdata <= dword;
         else if (hit_ctrl) bus_rdata <= cword;
         else               bus_rdata <= '0;
      end
   end

endmodule

// File: rtl/cons_checker.sv
module cons_checker #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CW     = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              tx_valid,
   input logic [7:0]        tx_data,
   input logic              tx_ready,
   input logic              irq,
   input logic [CW-1:0]     rx_cnt,
   input logic [CW-1:0]     tx_cnt,
   input logic              act_flag
);
   import console_pkg::*;

   logic rd_data, wr_ctrl;
   assign rd_data = bus_sel && !bus_wr && (bus_addr == ADDR_W'(DATA_OFF));
   assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(CTRL_OFF));

   AST_RD_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && rx_cnt != '0 && !(rx_valid && rx_ready)) |=> (rx_cnt == $past(rx_cnt) - CW'(1))); // R3

   AST_EMPTY_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && rx_cnt == '0) |=> (bus_rdata[15] == 1'b0 && bus_rdata[31:16] == 16'd0)); // R4

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt == CW'(DEPTH) && !(tx_valid && tx_ready)) |=> (tx_cnt == CW'(DEPTH))); // R6

   AST_RX_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == CW'(DEPTH)) |-> !rx_ready); // R7

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[1:0] == 2'b00) |=> !irq); // R10

   AST_ACT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_valid && rx_ready) || (tx_valid && tx_ready)) |=> act_flag); // R11 R12

endmodule

bind console_fifo_periph cons_checker #(
   .DEPTH  (DEPTH),
   .ADDR_W (ADDR_W),
   .CW     (CW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .tx_valid  (tx_valid),
   .tx_data   (tx_data),
   .tx_ready  (tx_ready),
   .irq       (irq),
   .rx_cnt    (rx_cnt),
   .tx_cnt    (tx_cnt),
   .act_flag  (act_flag)
);

// File: tb/tb_console_fifo_periph.sv
`timescale 1ns/1ps
module tb_console_fifo_periph;

   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready, tx_valid, tx_ready = 1'b0, irq;
   logic [7:0]  tx_data;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   console_fifo_periph dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rx_send(input logic [7:0] b);
      rx_valid = 1'b1; rx_data = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic tx_take(output logic [7:0] b);
      b = tx_data;
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] r;
      chk(tx_valid == 1'b0, "R1 tx_valid", 32'(tx_valid), 0);
      chk(rx_ready == 1'b1, "R1 rx_ready", 32'(rx_ready), 1);
      chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
      rd_reg(4'h4, r);
      chk(r == 32'h0040_0200, "R1 ctrl after reset", r, 32'h0040_0200);
      rd_reg(4'h0, r);
      chk(r[31:8] == 24'h0, "R4 empty data read", r, 0);
   endtask

   task automatic t_rx_read();
      logic [31:0] r;
      rx_send(8'hA1); rx_send(8'hB2); rx_send(8'hC3);
      rd_reg(4'h4, r);
      chk(r[8] == 1'b1, "R9 read pending", r, 32'h100);
      rd_reg(4'h0, r);
      chk(r == 32'h0002_80A1, "R2 first read word", r, 32'h0002_80A1);
      rd_reg(4'h0, r);
      chk(r == 32'h0001_80B2, "R3 second read word", r, 32'h0001_80B2);
      rd_reg(4'h0, r);
      chk(r == 32'h0000_80C3, "R3 third read word", r, 32'h0000_80C3);
      rd_reg(4'h0, r);
      chk(r[15] == 1'b0 && r[31:16] == 16'h0, "R4 read after drain", r, 0);
      rd_reg(4'h4, r);
      chk(r[8] == 1'b0, "R9 read pending clear", r, 0);
   endtask

   task automatic t_activity();
      logic [31:0] r;
      wr_reg(4'h4, 32'h0000_0400);
      rd_reg(4'h4, r);
      chk(r[10] == 1'b0, "R11 cleared by write one", r, 0);
      rx_send(8'h11);
      rd_reg(4'h4, r);
      chk(r[10] == 1'b1, "R11 set by receive", r, 32'h400);
      wr_reg(4'h4, 32'h0000_0000);
      rd_reg(4'h4, r);
      chk(r[10] == 1'b1, "R11 write zero keeps flag", r, 32'h400);
      // clear and receive in the same cycle
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0000_0400;
      rx_valid = 1'b1; rx_data = 8'h22;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
      rd_reg(4'h4, r);
      chk(r[10] == 1'b1, "R12 set wins over clear", r, 32'h400);
      rd_reg(4'h0, r);
      chk(r == 32'h0001_8011, "R2 activity bytes", r, 32'h0001_8011);
      rd_reg(4'h0, r);
      wr_reg(4'h4, 32'h0000_0400);
   endtask

   task automatic t_tx();
      logic [31:0] r;
      logic [7:0] b;
      wr_reg(4'h0, 32'hFFFF_FF5A);
      wr_reg(4'h0, 32'h1234_0077);
      chk(tx_valid == 1'b1 && tx_data == 8'h5A, "R5 head byte", 32'(tx_data), 32'h5A);
      rd_reg(4'h4, r);
      chk(r[31:16] == 16'd62, "R8 free space", r, 32'h003E_0000);
      @(negedge clk);
      chk(tx_valid == 1'b1 && tx_data == 8'h5A, "R5 held without ready", 32'(tx_data), 32'h5A);
      tx_take(b);
      chk(b == 8'h5A, "R5 first out", 32'(b), 32'h5A);
      tx_take(b);
      chk(b == 8'h77, "R5 upper bits ignored", 32'(b), 32'h77);
      chk(tx_valid == 1'b0, "R5 empty after drain", 32'(tx_valid), 0);
      rd_reg(4'h4, r);
      chk(r[10] == 1'b1, "R11 set by transmit", r, 32'h400);
      wr_reg(4'h4, 32'h0000_0400);
   endtask

   task automatic t_tx_full();
      logic [31:0] r;
      logic [7:0] b;
      for (int i = 0; i < 32; i++) wr_reg(4'h0, 32'(i + 8'h40));
      rd_reg(4'h4, r);
      chk(r[9] == 1'b1, "R9 write pending at threshold", r, 32'h200);
      wr_reg(4'h0, 32'(8'h60));
      rd_reg(4'h4, r);
      chk(r[9] == 1'b0, "R9 write pending below threshold", r, 0);
      for (int i = 33; i < DEPTH; i++) wr_reg(4'h0, 32'(i + 8'h40));
      rd_reg(4'h4, r);
      chk(r[31:16] == 16'd0, "R8 free space zero", r, 0);
      wr_reg(4'h0, 32'h0000_00EE);
      for (int i = 0; i < DEPTH; i++) begin
         tx_take(b);
         chk(b == 8'(i + 8'h40), "R6 order after full", 32'(b), 32'(8'(i + 8'h40)));
      end
      chk(tx_valid == 1'b0, "R6 dropped write absent", 32'(tx_data), 0);
      wr_reg(4'h4, 32'h0000_0400);
   endtask

   task automatic t_rx_full();
      logic [31:0] r;
      for (int i = 0; i < DEPTH; i++) rx_send(8'(i + 1));
      chk(rx_ready == 1'b0, "R7 ready low when full", 32'(rx_ready), 0);
      rx_send(8'hFF);
      rd_reg(4'h0, r);
      chk(r == 32'h003F_8001, "R2 full first word", r, 32'h003F_8001);
      for (int i = 1; i < DEPTH - 1; i++) rd_reg(4'h0, r);
      rd_reg(4'h0, r);
      chk(r == 32'h0000_8040, "R7 refused byte absent", r, 32'h0000_8040);
      rd_reg(4'h0, r);
      chk(r[15] == 1'b0, "R4 empty after full drain", r, 0);
      wr_reg(4'h4, 32'h0000_0400);
   endtask

   task automatic t_irq();
      logic [31:0] r;
      logic [7:0] b;
      wr_reg(4'h4, 32'h0000_0002);
      chk(irq == 1'b1, "R10 write enable with space", 32'(irq), 1);
      wr_reg(4'h4, 32'h0000_0001);
      chk(irq == 1'b0, "R10 read enable while empty", 32'(irq), 0);
      rx_send(8'h33);
      chk(irq == 1'b1, "R10 read enable with byte", 32'(irq), 1);
      rd_reg(4'h4, r);
      chk(r[1:0] == 2'b01, "R8 enable readback", r, 1);
      wr_reg(4'h4, 32'hFFFF_FBFC);
      chk(irq == 1'b0, "R10 both disabled", 32'(irq), 0);
      rd_reg(4'h4, r);
      chk(r[7:0] == 8'h00 && r[15:11] == 5'h0, "R8 reserved bits zero", r, r & 32'hFFFF_0700);
      rd_reg(4'h0, r);
      chk(r == 32'h0000_8033, "R2 irq byte", r, 32'h0000_8033);
      for (int i = 0; i < 40; i++) wr_reg(4'h0, 32'h0);
      wr_reg(4'h4, 32'h0000_0002);
      chk(irq == 1'b0, "R10 pending low masks irq", 32'(irq), 0);
      for (int i = 0; i < 40; i++) tx_take(b);
      chk(irq == 1'b1, "R10 space returns", 32'(irq), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rx_read();
      t_activity();
      t_tx();
      t_tx_full();
      t_rx_full();
      t_irq();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule